// File: doc/BRIEF.md
# Hardware Mutex Register Bank

This block is a bank of single-bit hardware mutexes that several processors reach over a shared register bus. Each mutex sits behind its own 32-bit word. A read of that word is the acquire operation. It reports whether the mutex was free and, in the same access, marks it held. A processor that reads back zero owns the mutex. It gives the mutex back by writing zero to the same word.

A read-only status word tells software how large the bank is. The bank size is a parameter. The status word carries the size as a power-of-two code in its upper nibble. All reads are registered, so the data appears one cycle after the read strobe. Locks beyond the configured count always read as held, so software can never believe it owns a mutex that is not there.

Top module: `hwmutex_bank`

## Requirements
- R1: The status word at byte offset 0x000 reads `{CODE, 28'h0}`, where CODE = log2(NUM_LOCKS) - 4. CODE is 1, 2, 3 or 4 for 32, 64, 128 or 256 locks, so a 32-lock bank reads 0x10000000. NUM_LOCKS must be one of those four values; any other value is rejected at elaboration.
- R2: Lock i lives at byte offset 0x100 + 4*i. Address bits 1:0 are ignored.
- R3: A read of a free lock returns 0x00000000 and marks the lock held. rd_data is registered and valid in the cycle after rd_en.
- R4: A read of a held lock returns 0x00000001 and leaves it held.
- R5: A write of 0x00000000 to a lock's word frees that lock.
- R6: A write of any nonzero value to a lock's word has no effect. Any write to the status word has no effect.
- R7: A read of a lock-window slot at or beyond NUM_LOCKS (byte offsets 0x100+4*NUM_LOCKS up to 0x4FC) returns 0x00000001 and changes no lock. Reads of addresses outside the status word and the lock window return 0.
- R8: Reset (synchronous, active high) frees every lock and clears rd_data to 0.
- R9: rd_data holds its value in cycles without rd_en. If rd_en and wr_en are both high, the read is performed and the write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address of the access |
| rd_en | input | 1 | Read strobe; acquires the addressed lock |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data; zero releases a lock |
| rd_data | output | 32 | Registered read data |

## Verification
The assertions assume that the bus presents at most one access per cycle. They also assume that wr_data is known whenever wr_en is high. Cases where both strobes are high are covered only by the rule that reads take priority. The bench drives every access from a negedge-aligned task that raises exactly one strobe for one cycle. The one exception is a deliberate simultaneous read and write, which it uses to exercise that rule. The sweeps run over all 32 locks and all 224 unused window slots of the 32-lock configuration.

// File: rtl/hwmutex_pkg.sv
package hwmutex_pkg;
  localparam int DATA_W      = 32;
  localparam int CODE_LSB    = 28;
  localparam int WIN_SLOTS   = 256;
  localparam int WIN_BASE_WD = 'h40;   // 0x100 >> 2

  function automatic logic [3:0] count_code(input int n);
    case (n)
      32:      return 4'd1;
      64:      return 4'd2;
      128:     return 4'd3;
      256:     return 4'd4;
      default: return 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/hwmutex_addr_dec.sv
module hwmutex_addr_dec #(
  parameter int ADDR_W    = 12,
  parameter int NUM_LOCKS = 32,
  parameter int IDX_W     = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_status,
  output logic              hit_window,
  output logic              hit_lock,
  output logic [IDX_W-1:0]  idx
);
  import hwmutex_pkg::*;
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] slot_full;
  logic [8:0]        slot;
  logic              unused_lo;

  assign word       = addr[ADDR_W-1:2];
  assign unused_lo  = ^addr[1:0];
  assign slot_full  = word - WORD_W'(WIN_BASE_WD);
  assign slot       = {1'b0, slot_full[7:0]};
  assign hit_status = (word == '0);
  assign hit_window = (word >= WORD_W'(WIN_BASE_WD)) &&
                      (word <  WORD_W'(WIN_BASE_WD + WIN_SLOTS));
  assign hit_lock   = hit_window && (slot < 9'(NUM_LOCKS));
  assign idx        = slot_full[IDX_W-1:0];
endmodule

// File: rtl/hwmutex_lock_array.sv
module hwmutex_lock_array #(
  parameter int NUM_LOCKS = 32,
  parameter int IDX_W     = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 acq,
  input  logic                 rel,
  input  logic [IDX_W-1:0]     idx,
  output logic [NUM_LOCKS-1:0] locks
);
  for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
    logic sel;
    assign sel = (idx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst)
        locks[i] <= 1'b0;
      else if (acq && sel)
        locks[i] <= 1'b1;
      else if (rel && sel)
        locks[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/hwmutex_rd_port.sv
module hwmutex_rd_port #(
  parameter logic [3:0] CODE = 4'd1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_en,
  input  logic        hit_status,
  input  logic        hit_window,
  input  logic        hit_lock,
  input  logic        lock_bit,
  output logic [31:0] rd_data
);
  import hwmutex_pkg::*;
  logic [31:0] nxt;

  always_comb begin
    if (hit_status)      nxt = {CODE, 28'h0};
    else if (hit_lock)   nxt = {31'h0, lock_bit};
    else if (hit_window) nxt = 32'h1;
    else                 nxt = 32'h0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= nxt;
  end
endmodule

// File: rtl/hwmutex_bank.sv
module hwmutex_bank #(
  parameter int ADDR_W    = 12,
  parameter int NUM_LOCKS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data
);
  import hwmutex_pkg::*;
  localparam int         IDX_W = $clog2(NUM_LOCKS);
  localparam logic [3:0] CODE  = count_code(NUM_LOCKS);

  // R1: only 32, 64, 128 or 256 locks are accepted
  if (CODE == 4'd0) begin : g_bad_count
    $error("hwmutex_bank: NUM_LOCKS must be 32, 64, 128 or 256");
  end

  logic                 hit_status, hit_window, hit_lock;
  logic [IDX_W-1:0]     idx;
  logic [NUM_LOCKS-1:0] locks;
  logic                 acq, rel;

  hwmutex_addr_dec #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_dec (
    .addr(addr), .hit_status(hit_status), .hit_window(hit_window),
    .hit_lock(hit_lock), .idx(idx)
  );

  assign acq = rd_en && hit_lock;
  assign rel = wr_en && !rd_en && hit_lock && (wr_data == 32'h0);

  hwmutex_lock_array #(.NUM_LOCKS(NUM_LOCKS), .IDX_W(IDX_W)) u_locks (
    .clk(clk), .rst(rst), .acq(acq), .rel(rel), .idx(idx), .locks(locks)
  );

  hwmutex_rd_port #(.CODE(CODE)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .hit_status(hit_status),
    .hit_window(hit_window), .hit_lock(hit_lock), .lock_bit(locks[idx]),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/hwmutex_bank_chk.sv
module hwmutex_bank_chk #(
  parameter int ADDR_W    = 12,
  parameter int NUM_LOCKS = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic [ADDR_W-1:0]    addr,
  input logic                 rd_en,
  input logic                 wr_en,
  input logic [31:0]          wr_data,
  input logic [31:0]          rd_data,
  input logic [NUM_LOCKS-1:0] lock_state
);
  int        baddr;
  logic      in_win, valid, is_stat;
  logic [7:0] cidx;
  logic [31:0] stat_val;

  always_comb begin
    baddr    = int'(addr) & ~3;
    is_stat  = (baddr == 0);
    in_win   = (baddr >= 'h100) && (baddr < 'h500);
    cidx     = 8'((baddr - 'h100) / 4);
    valid    = in_win && (int'(cidx) < NUM_LOCKS);
    stat_val = 32'(($clog2(NUM_LOCKS) - 4)) << 28;
  end

  a_r1_status_word: assert property (@(posedge clk) disable iff (rst)
    (rd_en && is_stat) |=> (rd_data == $past(stat_val)));

  a_r3_acquire_sets: assert property (@(posedge clk) disable iff (rst)
    (rd_en && valid) |=> lock_state[$past(cidx)]);

  a_r4_read_reports_prior: assert property (@(posedge clk) disable iff (rst)
    (rd_en && valid) |=> (rd_data == {31'h0, $past(lock_state[cidx])}));

  a_r5_release: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && valid && wr_data == 32'h0) |=> !lock_state[$past(cidx)]);

  a_r6_no_effect_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en && (!valid || wr_data != 32'h0)) |=> $stable(lock_state));

  a_r7_beyond_count: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_win && !valid) |=> (rd_data == 32'h1 && $stable(lock_state)));

  a_r8_reset_clear: assert property (@(posedge clk)
    rst |=> (lock_state == '0 && rd_data == 32'h0));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind hwmutex_bank hwmutex_bank_chk #(.ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wr_data(wr_data), .rd_data(rd_data), .lock_state(locks)
);

// File: tb/hwmutex_bank_bench.sv
module hwmutex_bank_bench;
  localparam int ADDR_W = 12;
  localparam int NLOCK  = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic              rd_en = 1'b0;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic [31:0]       rd_data;
  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;

  always #4 clk = ~clk;   // 125 MHz

  hwmutex_bank #(.ADDR_W(ADDR_W), .NUM_LOCKS(NLOCK)) u_hwmutex_bank (
    .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic bus_wr(input int a, input logic [31:0] v);
    @(negedge clk);
    addr = ADDR_W'(a); wr_data = v; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic int lock_addr(input int i);
    return 'h100 + 4 * i;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    check("R8 rd_data after reset", rd_data, 32'h0);
    rst = 1'b0;

    // R1: status word, code = log2(32)-4 = 1
    bus_rd('h000, d); check("R1 status", d, 32'h1000_0000);
    bus_rd('h003, d); check("R1 status low bits ignored", d, 32'h1000_0000);

    // R8 + R3: every lock free after reset, first read acquires
    for (int i = 0; i < NLOCK; i++) begin
      bus_rd(lock_addr(i), d); check("R3 first read free", d, 32'h0);
    end
    // R4: second read sees held
    for (int i = 0; i < NLOCK; i++) begin
      bus_rd(lock_addr(i), d); check("R4 second read held", d, 32'h1);
    end
    // R9: rd_data holds without a read
    repeat (3) @(negedge clk);
    check("R9 hold", rd_data, 32'h1);

    // R6: nonzero writes and status writes have no effect
    for (int i = 0; i < NLOCK; i++) bus_wr(lock_addr(i), 32'(i + 1));
    bus_wr('h000, 32'h0);
    bus_wr('h000, 32'hFFFF_FFFF);
    for (int i = 0; i < NLOCK; i++) begin
      bus_rd(lock_addr(i), d); check("R6 nonzero write ignored", d, 32'h1);
    end
    bus_rd('h000, d); check("R6 status unchanged", d, 32'h1000_0000);

    // R5: release even locks with zero
    for (int i = 0; i < NLOCK; i += 2) bus_wr(lock_addr(i), 32'h0);
    for (int i = 0; i < NLOCK; i++) begin
      bus_rd(lock_addr(i), d);
      check("R5 release even only", d, (i % 2 == 0) ? 32'h0 : 32'h1);
    end

    // R2: low address bits ignored on lock words
    bus_wr(lock_addr(5) + 2, 32'h0);
    bus_rd(lock_addr(5) + 1, d); check("R2 low bits ignored release/acquire", d, 32'h0);
    bus_rd(lock_addr(5) + 3, d); check("R2 same lock held", d, 32'h1);

    // release all, then sweep the unused window
    for (int i = 0; i < NLOCK; i++) bus_wr(lock_addr(i), 32'h0);
    for (int s = NLOCK; s < 256; s++) begin
      bus_rd(lock_addr(s), d); check("R7 beyond count reads one", d, 32'h1);
    end
    for (int i = 0; i < NLOCK; i++) begin
      bus_rd(lock_addr(i), d); check("R7 beyond reads left locks free", d, 32'h0);
    end
    bus_rd('h004, d);  check("R7 gap reads zero", d, 32'h0);
    bus_rd('h0FC, d);  check("R7 below window reads zero", d, 32'h0);
    bus_rd('h500, d);  check("R7 above window reads zero", d, 32'h0);

    // R9: simultaneous read and write, read wins
    @(negedge clk);
    addr = ADDR_W'(lock_addr(7)); wr_data = 32'h0; rd_en = 1'b1; wr_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R9 rd+wr returns held", rd_data, 32'h1);
    bus_rd(lock_addr(7), d); check("R9 rd+wr write ignored", d, 32'h1);

    // R8: reset mid-run frees everything
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R8 rd_data cleared", rd_data, 32'h0);
    for (int i = 0; i < NLOCK; i++) begin
      bus_rd(lock_addr(i), d); check("R8 locks free after reset", d, 32'h0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule